// File: doc/BRIEF.md
# Pulse-Driven One-Time Trim Programming Controller

This block is the sequencer that writes a one-time-programmable trim store from a stream of two kinds of programming strobes. A mid strobe marks the falling edge of a medium-level pulse. A high strobe marks a high-level pulse. Starting from an idle state, a high strobe opens register selection. Mid strobes then count a key, and a second high strobe enters addressing for the chosen register. In addressing, mid strobes step a trial code upward. While the code is being stepped, the code already drives the trim outputs, so the effect of a candidate value can be measured before anything is made permanent.

A final high strobe burns one fuse. That fuse is the single set bit of the trial code. After the burn the sequencer is inert until the supply is cycled. The fuse array is modelled as flops. The power-cycle input clears only the volatile sequencer state, and only the global reset clears the fuses. Blowing the lock bit of the second register freezes the whole store.

Register 0 holds the sensitivity trim. Register 1 holds the offset trim in its low bits, and the bit above them is the lock fuse.

Top module: `fuse_trim_prog`

## Requirements
- R1: After reset the trim outputs, `trim_locked` and `blow_en` are all 0.
- R2: In the idle state mid strobes are ignored: they do not add to the key that the next selection counts.
- R3: After the opening high strobe, the number of mid strobes before the next high strobe is the key. Key 1 selects register 0 (sensitivity). Key 2 selects register 1 (offset plus lock). Any other key puts the sequencer in a fault state in which further strobes change nothing until a power cycle.
- R4: In addressing, each mid strobe raises the trial code by exactly one. The code never decreases, and the selected trim output shows fuse bits OR trial code in the cycle after the strobe.
- R5: The trial code stops at 63 for register 0 and at 32 for register 1. Code 32 is bit 5 of register 1, the lock bit, and it does not appear on `ofs_trim`.
- R6: A high strobe in addressing whose code has exactly one bit set raises `blow_en` for one cycle. In the same cycle `blow_reg` gives the register and `blow_bit` gives that bit's index, and the bit is then set in the fuse array.
- R7: A high strobe in addressing with a code of zero or with more than one bit set blows nothing, and the sequencer enters the fault state.
- R8: After a blow, every strobe is ignored until a power cycle.
- R9: A power cycle clears the trial code and the sequencer state but keeps the blown bits. Fuse bits and trial code combine by OR.
- R10: Once the lock fuse is blown, `trim_locked` is 1. High strobes after the next power cycle no longer leave the idle state, so no trim can change.
- R11: A power cycle in the same cycle as a high strobe wins, and no fuse is blown. A high strobe in the same cycle as a mid strobe wins, and the mid strobe is ignored.
- R12: The register that is not selected shows only its fuse bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of everything, fuses included (fresh die) |
| pwr_cycle | input | 1 | Supply-cycle event: clears volatile state only |
| mid_pulse | input | 1 | One-cycle strobe at the falling edge of a mid-level pulse |
| high_pulse | input | 1 | One-cycle strobe for a high-level pulse |
| sens_trim | output | SENS_W | Effective sensitivity trim code |
| ofs_trim | output | OFS_W | Effective offset trim code |
| trim_locked | output | 1 | Lock fuse state |
| blow_en | output | 1 | One-cycle fuse burn request |
| blow_reg | output | 1 | Register of the fuse to burn |
| blow_bit | output | IDX_W | Bit index of the fuse to burn |

## Verification
A burn request can coincide with a power cycle, and a high strobe can coincide with a mid strobe. The bench drives both pairs in one clock while the sequencer is addressing. The power cycle must win: `blow_en` stays low and the offset trial code is gone from `ofs_trim`. When high meets mid, the burn must take the code as it stood before the strobe. The bench judges this from `blow_bit` and from the sensitivity trim after the next power cycle.

// File: rtl/fuse_trim_pkg.sv
package fuse_trim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_ADDRESS,
        ST_HOLD,
        ST_FAULT
    } prog_st_e;

endpackage

// File: rtl/ftp_fuse_bank.sv
module ftp_fuse_bank #(
    parameter int W     = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blow_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [W-1:0]     fuse_o
);

    logic [W-1:0] fuse_d, fuse_q;

    always_comb begin
        fuse_d = fuse_q;
        if (blow_i) begin
            fuse_d = fuse_q | (W'(1) << idx_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fuse_q <= '0;
        else        fuse_q <= fuse_d;
    end

    assign fuse_o = fuse_q;

    // a burned bit never returns to 0
    p_fuse_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(fuse_q) & ~fuse_q) == '0));

    // at most one new bit per clock
    p_one_bit_per_blow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(fuse_q ^ $past(fuse_q)) <= 1));

    // without a request the array is unchanged
    p_no_spontaneous_burn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !blow_i |=> $stable(fuse_q));

endmodule

// File: rtl/ftp_seq.sv
module ftp_seq
    import fuse_trim_pkg::*;
#(
    parameter int SENS_W = 6,
    parameter int OFS_W  = 5,
    parameter int CODE_W = 6,
    parameter int NREG   = 2,
    parameter int KEY_W  = 3,
    parameter int SEL_W  = 1,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_cyc_i,
    input  logic              mid_i,
    input  logic              high_i,
    input  logic              locked_i,
    output logic              try_act_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [CODE_W-1:0] code_o,
    output logic              blow_o,
    output logic [SEL_W-1:0]  blow_sel_o,
    output logic [IDX_W-1:0]  blow_idx_o
);

    localparam logic [KEY_W-1:0] KEY_MAX = '1;
    localparam logic [KEY_W-1:0] KEY_TOP = KEY_W'(NREG);

    typedef struct packed {
        prog_st_e          st;
        logic [KEY_W-1:0]  key;
        logic [SEL_W-1:0]  sel;
        logic [CODE_W-1:0] code;
        logic              blow;
        logic [IDX_W-1:0]  idx;
    } seq_t;

    seq_t q, d;

    function automatic logic [CODE_W-1:0] max_code(input logic [SEL_W-1:0] s);
        if (s == '0) max_code = CODE_W'((1 << SENS_W) - 1);
        else         max_code = CODE_W'(1 << OFS_W);
    endfunction

    function automatic logic [IDX_W-1:0] bit_pos(input logic [CODE_W-1:0] c);
        bit_pos = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (c[i]) bit_pos = IDX_W'(i);
        end
    endfunction

    always_comb begin
        d      = q;
        d.blow = 1'b0;
        if (pwr_cyc_i) begin
            d.st   = ST_IDLE;
            d.key  = '0;
            d.code = '0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (high_i && !locked_i) begin
                        d.st  = ST_SELECT;
                        d.key = '0;
                    end
                end
                ST_SELECT: begin
                    if (high_i) begin
                        if (q.key != '0 && q.key <= KEY_TOP) begin
                            d.st   = ST_ADDRESS;
                            d.sel  = SEL_W'(q.key - 1'b1);
                            d.code = '0;
                        end else begin
                            d.st = ST_FAULT;
                        end
                    end else if (mid_i && q.key != KEY_MAX) begin
                        d.key = q.key + 1'b1;
                    end
                end
                ST_ADDRESS: begin
                    if (high_i) begin
                        if ($onehot(q.code) && !locked_i) begin
                            d.st   = ST_HOLD;
                            d.blow = 1'b1;
                            d.idx  = bit_pos(q.code);
                        end else begin
                            d.st = ST_FAULT;
                        end
                    end else if (mid_i && q.code < max_code(q.sel)) begin
                        d.code = q.code + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.key  <= '0;
            q.sel  <= '0;
            q.code <= '0;
            q.blow <= 1'b0;
            q.idx  <= '0;
        end else begin
            q <= d;
        end
    end

    assign try_act_o  = (q.st == ST_ADDRESS) || (q.st == ST_HOLD);
    assign sel_o      = q.sel;
    assign code_o     = q.code;
    assign blow_o     = q.blow;
    assign blow_sel_o = q.sel;
    assign blow_idx_o = q.idx;

    p_idle_ignores_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && mid_i && !high_i && !pwr_cyc_i) |=> (q.st == ST_IDLE && q.key == '0));

    p_code_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDRESS && !pwr_cyc_i) |=> (q.code >= $past(q.code)));

    p_code_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDRESS) |-> (q.code <= max_code(q.sel)));

    p_blow_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.blow |-> (q.st == ST_HOLD && q.code[q.idx]));

    p_hold_is_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && !pwr_cyc_i) |=> (q.st == ST_HOLD && !q.blow));

    p_fault_is_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FAULT && !pwr_cyc_i) |=> (q.st == ST_FAULT && !q.blow));

    p_locked_stays_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && locked_i) |=> (q.st == ST_IDLE));

    p_pwr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cyc_i |=> (q.st == ST_IDLE && !q.blow));

endmodule

// File: rtl/fuse_trim_prog.sv
module fuse_trim_prog #(
    parameter int SENS_W = 6,
    parameter int OFS_W  = 5,
    parameter int KEY_W  = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   pwr_cycle,
    input  logic                                   mid_pulse,
    input  logic                                   high_pulse,
    output logic [SENS_W-1:0]                      sens_trim,
    output logic [OFS_W-1:0]                       ofs_trim,
    output logic                                   trim_locked,
    output logic                                   blow_en,
    output logic                                   blow_reg,
    output logic [$clog2((SENS_W > OFS_W) ? SENS_W : OFS_W + 1)-1:0] blow_bit
);

    localparam int NREG   = 2;
    localparam int SEL_W  = 1;
    localparam int CODE_W = (SENS_W > OFS_W) ? SENS_W : OFS_W + 1;
    localparam int IDX_W  = $clog2(CODE_W);

    logic              try_act;
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] code;
    logic              blow;
    logic [SEL_W-1:0]  blow_sel;
    logic [IDX_W-1:0]  blow_idx;
    logic [CODE_W-1:0] fuse   [NREG];
    logic [CODE_W-1:0] eff    [NREG];

    ftp_seq #(
        .SENS_W (SENS_W),
        .OFS_W  (OFS_W),
        .CODE_W (CODE_W),
        .NREG   (NREG),
        .KEY_W  (KEY_W),
        .SEL_W  (SEL_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_cyc_i  (pwr_cycle),
        .mid_i      (mid_pulse),
        .high_i     (high_pulse),
        .locked_i   (trim_locked),
        .try_act_o  (try_act),
        .sel_o      (sel),
        .code_o     (code),
        .blow_o     (blow),
        .blow_sel_o (blow_sel),
        .blow_idx_o (blow_idx)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_bank
        ftp_fuse_bank #(
            .W     (CODE_W),
            .IDX_W (IDX_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .blow_i (blow && (blow_sel == SEL_W'(r))),
            .idx_i  (blow_idx),
            .fuse_o (fuse[r])
        );

        always_comb begin
            eff[r] = fuse[r];
            if (try_act && sel == SEL_W'(r)) eff[r] = fuse[r] | code;
        end
    end

    assign sens_trim   = eff[0][SENS_W-1:0];
    assign ofs_trim    = eff[1][OFS_W-1:0];
    assign trim_locked = fuse[1][OFS_W];
    assign blow_en     = blow;
    assign blow_reg    = blow_sel;
    assign blow_bit    = blow_idx;

    p_no_blow_when_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blow_en |-> !trim_locked);

    p_unselected_fuse_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (try_act && sel == 1'b1) |-> (sens_trim == fuse[0][SENS_W-1:0]));

    p_lock_bit_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_trim == (fuse[1][OFS_W-1:0] | ((try_act && sel == 1'b1) ? code[OFS_W-1:0] : '0))));

endmodule

// File: tb/test_fuse_trim_prog.sv
module test_fuse_trim_prog;

    localparam int OP_MID = 0, OP_HIGH = 1, OP_PWR = 2, OP_BOTH = 3, OP_PWRH = 4, OP_NOP = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_cycle = 1'b0;
    logic       mid_pulse = 1'b0;
    logic       high_pulse = 1'b0;
    logic [5:0] sens_trim;
    logic [4:0] ofs_trim;
    logic       trim_locked;
    logic       blow_en;
    logic       blow_reg;
    logic [2:0] blow_bit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fuse_trim_prog i_fuse_trim_prog (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_cycle   (pwr_cycle),
        .mid_pulse   (mid_pulse),
        .high_pulse  (high_pulse),
        .sens_trim   (sens_trim),
        .ofs_trim    (ofs_trim),
        .trim_locked (trim_locked),
        .blow_en     (blow_en),
        .blow_reg    (blow_reg),
        .blow_bit    (blow_bit)
    );

    // {op[2:0], sens[5:0], ofs[4:0], lock, blow, reg, bit[2:0]}
    localparam int NV = 37;
    localparam logic [19:0] VEC [NV] = '{
        {3'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 mid in idle
        {3'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R2
        {3'd1, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // open select
        {3'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // key 1
        {3'd1, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 address sens
        {3'd0, 6'd1, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R4
        {3'd0, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R4
        {3'd0, 6'd3, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R4
        {3'd1, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R7 code 3 -> fault
        {3'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R7 ignored
        {3'd1, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R7 ignored
        {3'd2, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R9 power cycle
        {3'd1, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd1, 6'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd1, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd1, 6'd2, 5'd0, 1'b0, 1'b1, 1'b0, 3'd1},  // R6 blow reg0 bit1
        {3'd0, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R8 ignored
        {3'd1, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R8 ignored
        {3'd2, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R9 fuse persists
        {3'd1, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd1, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd3, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R9 OR 2|1
        {3'd0, 6'd2, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd3, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd6, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // code 4
        {3'd3, 6'd6, 5'd0, 1'b0, 1'b1, 1'b0, 3'd2},  // R11 high beats mid
        {3'd2, 6'd6, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd1, 6'd6, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd6, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        {3'd0, 6'd6, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // key 2
        {3'd1, 6'd6, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 address offset
        {3'd0, 6'd6, 5'd1, 1'b0, 1'b0, 1'b0, 3'd0},  // R12 sens fuse only
        {3'd0, 6'd6, 5'd2, 1'b0, 1'b0, 1'b0, 3'd0},  // R12
        {3'd4, 6'd6, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0}   // R11 power beats blow
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_op(input int op);
        @(negedge clk);
        mid_pulse  = (op == OP_MID) || (op == OP_BOTH);
        high_pulse = (op == OP_HIGH) || (op == OP_BOTH) || (op == OP_PWRH);
        pwr_cycle  = (op == OP_PWR) || (op == OP_PWRH);
        @(posedge clk);
        @(negedge clk);
        mid_pulse  = 1'b0;
        high_pulse = 1'b0;
        pwr_cycle  = 1'b0;
    endtask

    task automatic check_all(input string req, input int s, input int o, input int l, input int b);
        chk({req, " sens_trim"}, int'(sens_trim), s);
        chk({req, " ofs_trim"}, int'(ofs_trim), o);
        chk({req, " trim_locked"}, int'(trim_locked), l);
        chk({req, " blow_en"}, int'(blow_en), b);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            do_op(int'(VEC[i][19:17]));
            check_all($sformatf("vec%0d R2-R12 table", i), int'(VEC[i][16:11]),
                      int'(VEC[i][10:6]), int'(VEC[i][5]), int'(VEC[i][4]));
            if (VEC[i][4]) begin
                chk($sformatf("vec%0d R6 blow_reg", i), int'(blow_reg), int'(VEC[i][3]));
                chk($sformatf("vec%0d R6 blow_bit", i), int'(blow_bit), int'(VEC[i][2:0]));
            end
        end

        // R3: key 3 faults, later mids change nothing
        do_op(OP_HIGH);
        repeat (3) do_op(OP_MID);
        do_op(OP_HIGH);
        do_op(OP_MID);
        check_all("R3 bad key fault", 6, 0, 0, 0);
        do_op(OP_PWR);

        // R5: sensitivity saturates at 63
        do_op(OP_HIGH); do_op(OP_MID); do_op(OP_HIGH);
        repeat (70) do_op(OP_MID);
        check_all("R5 sens ceiling", 63, 0, 0, 0);
        do_op(OP_PWR);
        check_all("R9 sens back to fuses", 6, 0, 0, 0);

        // R5/R10: offset ceiling at lock bit, then lock
        do_op(OP_HIGH); do_op(OP_MID); do_op(OP_MID); do_op(OP_HIGH);
        repeat (31) do_op(OP_MID);
        check_all("R5 offset code 31", 6, 31, 0, 0);
        do_op(OP_MID);
        check_all("R5 code 32 hidden", 6, 0, 0, 0);
        repeat (3) do_op(OP_MID);
        check_all("R5 offset ceiling", 6, 0, 0, 0);
        do_op(OP_HIGH);
        check_all("R6 lock blow", 6, 0, 0, 1);
        chk("R6 lock blow_reg", int'(blow_reg), 1);
        chk("R6 lock blow_bit", int'(blow_bit), 5);
        do_op(OP_NOP);
        check_all("R10 locked", 6, 0, 1, 0);
        do_op(OP_PWR);
        do_op(OP_HIGH); do_op(OP_MID); do_op(OP_HIGH); do_op(OP_MID);
        check_all("R10 frozen sens", 6, 0, 1, 0);
        do_op(OP_HIGH); do_op(OP_MID); do_op(OP_MID); do_op(OP_HIGH); do_op(OP_MID);
        check_all("R10 frozen offset", 6, 0, 1, 0);

        finish_run();
    end

endmodule